// File: doc/BRIEF.md
# Byte-Wide Host Bus Slave with Control Register

This block connects a 12-bit conversion engine to an 8-bit microprocessor bus. The bus uses active-low chip select, read and write strobes, plus two select lines. `hbe` picks the upper or lower half of a transfer. `sfr` picks the control/status register instead of the conversion result. The three-state data bus is modelled as an output-enable flag and a data-out vector, with a separate data-in vector for writes.

A host write stores the 2-bit channel address and can request a conversion or a calibration from the sequencer. A write to the register also sets three mode bits: output latching, sample/hold pin control and power-down. The block holds a power-fail flag and a calibration-error flag, and shows them in the register read. It also keeps the output holding register used in latched mode. In that mode, a finished result stays readable while the next conversion runs.

There is no streaming data path. Every pin is a plain control or status signal, so no valid/ready handshake applies.

Top module: `hbus_if`

## Requirements
- R1: `bus_oe` is high exactly while `cs_n` and `rd_n` are both low. Whenever `bus_oe` is low, `bus_dout` is all zeros.
- R2: A read with `sfr`=0 and `hbe`=0 drives result bits 7..0. If `hbe` changes during the read, the driven byte switches in the same cycle.
- R3: A read with `sfr`=0 and `hbe`=1 drives {`busy`, 0, 0, 0, result[11:8]}. Bit 7 is the live `busy` input.
- R4: A read with `sfr`=1 and `hbe`=1 drives the register. Bit 0 is latched mode, bit 1 is `cal_active`, bit 2 is sample/hold mode, bit 3 is power-down, bit 4 is 0, bit 5 is the power-fail flag, bit 6 is the calibration-error flag and bit 7 is `busy`.
- R5: A register write (`sfr`=1, `hbe`=1) takes effect at the first clock edge after the write strobe (`cs_n` low and `wr_n` low) ends. It copies `din[0]` to `mode_latched`, `din[2]` to `shc_mode` and `din[3]` to `pdown`.
- R6: A register write with `din[1]`=1 gives a one-cycle `cal_req` and no `start_req`. With `din[1]`=0 it gives a one-cycle `start_req`. The two requests never coincide.
- R7: A register write with `din[5]`=0 clears the power-fail flag. With `din[5]`=1 the flag is left as it was.
- R8: Every non-reserved write copies `addr` to `chan` at the end of the strobe. Code 0 selects channel 0 and code 3 selects channel 3.
- R9: A result write (`sfr`=0) gives a one-cycle `start_req` unless `shc_mode` is set. In sample/hold mode it only updates `chan`.
- R10: No `start_req` is issued for a write that ends while `busy` is high.
- R11: A write with `sfr`=1 and `hbe`=0 changes no state and issues no request. A read with `sfr`=1 and `hbe`=0 drives all zeros.
- R12: A `power_fail` pulse sets the power-fail flag and clears `mode_latched`, `shc_mode` and `pdown` at the next edge. It also gives a one-cycle `cal_req`.
- R13: A `cal_ovf` pulse sets the calibration-error flag. A `cal_start` pulse clears it.
- R14: With `mode_latched`=0, result reads show the live `result` input. With `mode_latched`=1, they show the value captured at the edge where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hbe | input | 1 | Upper-half / register select |
| sfr | input | 1 | Register space select |
| din | input | 8 | Bus data written by the host |
| addr | input | 2 | Channel address |
| bus_oe | output | 1 | Bus drive enable |
| bus_dout | output | 8 | Bus data driven to the host |
| busy | input | 1 | Conversion or calibration running |
| cal_active | input | 1 | Calibration running |
| cal_start | input | 1 | Pulse: a calibration has begun |
| cal_ovf | input | 1 | Pulse: calibration overflow |
| power_fail | input | 1 | Pulse: supply failure detected |
| result | input | 12 | Conversion result from the sequencer |
| start_req | output | 1 | One-cycle conversion request |
| cal_req | output | 1 | One-cycle calibration request |
| chan | output | 2 | Latched channel address |
| mode_latched | output | 1 | Latched output mode |
| shc_mode | output | 1 | Sample/hold pin control mode |
| pdown | output | 1 | Power-down mode |

## Verification
The read path is combinational from the pins and stored flags. The bench therefore checks `bus_oe` and `bus_dout` 1 ns after it drives a strobe or select change, well away from any clock edge. A write takes effect at the first rising edge after the strobe is released: the mode outputs and `chan` change there, and `start_req`/`cal_req` are high for that single cycle. The bench releases the strobe at a falling edge and samples at the next falling edge. `power_fail`, `cal_ovf`, `cal_start` and the `busy` fall that loads the holding register all act one edge after they are driven. Each is checked at the falling edge that follows.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_REG  = 2'd2,
    SEL_RSVD = 2'd3
  } sel_t;

  localparam int unsigned CB_MODE = 0;
  localparam int unsigned CB_CAL  = 1;
  localparam int unsigned CB_SHC  = 2;
  localparam int unsigned CB_PDN  = 3;
  localparam int unsigned CB_PF   = 5;
  localparam int unsigned CB_CERR = 6;
  localparam int unsigned CB_BUSY = 7;

  typedef struct packed {
    logic pdown;
    logic shc;
    logic mode;
  } ctrl_t;

  function automatic sel_t decode_sel(input logic sfr_i, input logic hbe_i);
    case ({sfr_i, hbe_i})
      2'b00:   decode_sel = SEL_LO;
      2'b01:   decode_sel = SEL_HI;
      2'b11:   decode_sel = SEL_REG;
      default: decode_sel = SEL_RSVD;
    endcase
  endfunction

endpackage

// File: rtl/hbus_strobe.sv
module hbus_strobe
  import hbus_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          hbe,
  input  logic          sfr,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] addr,
  output logic          rd_act,
  output sel_t          rd_sel,
  output logic          wr_commit,
  output sel_t          cap_sel,
  output logic [DW-1:0] cap_din,
  output logic [AW-1:0] cap_addr
);

  logic wr_act;
  logic wr_q;

  // Internal strobes: NOR of select and direction strobe
  assign rd_act = ~(cs_n | rd_n);
  assign wr_act = ~(cs_n | wr_n);
  assign rd_sel = decode_sel(sfr, hbe);

  // Write acts on the strobe's trailing (rising) edge, using the last
  // values seen while it was active
  assign wr_commit = wr_q & ~wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      cap_sel  <= SEL_LO;
      cap_din  <= '0;
      cap_addr <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act) begin
        cap_sel  <= decode_sel(sfr, hbe);
        cap_din  <= din;
        cap_addr <= addr;
      end
    end
  end

endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_commit,
  input  sel_t          cap_sel,
  input  logic [DW-1:0] cap_din,
  input  logic [AW-1:0] cap_addr,
  input  logic          busy,
  input  logic          cal_start,
  input  logic          cal_ovf,
  input  logic          power_fail,
  output ctrl_t         ctrl,
  output logic          pf_flag,
  output logic          cerr_flag,
  output logic [AW-1:0] chan,
  output logic          start_req,
  output logic          cal_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      pf_flag   <= 1'b0;
      cerr_flag <= 1'b0;
      chan      <= '0;
      start_req <= 1'b0;
      cal_req   <= 1'b0;
    end else begin
      start_req <= 1'b0;
      cal_req   <= 1'b0;

      if (cal_ovf)        cerr_flag <= 1'b1;
      else if (cal_start) cerr_flag <= 1'b0;

      if (power_fail) begin
        pf_flag <= 1'b1;
        ctrl    <= '0;
        cal_req <= 1'b1;
      end else if (wr_commit) begin
        case (cap_sel)
          SEL_REG: begin
            ctrl.mode  <= cap_din[CB_MODE];
            ctrl.shc   <= cap_din[CB_SHC];
            ctrl.pdown <= cap_din[CB_PDN];
            if (!cap_din[CB_PF]) pf_flag <= 1'b0;
            chan <= cap_addr;
            if (cap_din[CB_CAL]) cal_req   <= 1'b1;
            else                 start_req <= ~busy;
          end
          SEL_LO, SEL_HI: begin
            chan      <= cap_addr;
            start_req <= ~busy & ~ctrl.shc;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/hbus_rdmux.sv
module hbus_rdmux
  import hbus_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  sel_t          rd_sel,
  input  ctrl_t         ctrl,
  input  logic          pf_flag,
  input  logic          cerr_flag,
  input  logic          busy,
  input  logic          cal_active,
  input  logic [RW-1:0] result,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout
);

  localparam int unsigned HW  = RW - DW;
  localparam int unsigned PAD = DW - 1 - HW;

  logic          busy_q;
  logic [RW-1:0] hold;
  logic [RW-1:0] shown;
  logic [DW-1:0] reg_byte;

  // Output holding register: loaded when a conversion finishes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold   <= '0;
    end else begin
      busy_q <= busy;
      if (busy_q && !busy) hold <= result;
    end
  end

  assign shown = ctrl.mode ? hold : result;

  always_comb begin
    reg_byte          = '0;
    reg_byte[CB_MODE] = ctrl.mode;
    reg_byte[CB_CAL]  = cal_active;
    reg_byte[CB_SHC]  = ctrl.shc;
    reg_byte[CB_PDN]  = ctrl.pdown;
    reg_byte[CB_PF]   = pf_flag;
    reg_byte[CB_CERR] = cerr_flag;
    reg_byte[CB_BUSY] = busy;
  end

  always_comb begin
    bus_oe   = rd_act;
    bus_dout = '0;
    if (rd_act) begin
      case (rd_sel)
        SEL_LO:  bus_dout = shown[DW-1:0];
        SEL_HI:  bus_dout = {busy, {PAD{1'b0}}, shown[RW-1:DW]};
        SEL_REG: bus_dout = reg_byte;
        default: bus_dout = '0;
      endcase
    end
  end

endmodule

// File: rtl/hbus_if.sv
module hbus_if
  import hbus_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned RW = 12,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          hbe,
  input  logic          sfr,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] addr,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout,
  input  logic          busy,
  input  logic          cal_active,
  input  logic          cal_start,
  input  logic          cal_ovf,
  input  logic          power_fail,
  input  logic [RW-1:0] result,
  output logic          start_req,
  output logic          cal_req,
  output logic [AW-1:0] chan,
  output logic          mode_latched,
  output logic          shc_mode,
  output logic          pdown
);

  logic          rd_act;
  sel_t          rd_sel;
  logic          wr_commit;
  sel_t          cap_sel;
  logic [DW-1:0] cap_din;
  logic [AW-1:0] cap_addr;
  ctrl_t         ctrl;
  logic          pf_flag;
  logic          cerr_flag;

  hbus_strobe #(.DW(DW), .AW(AW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .hbe(hbe), .sfr(sfr), .din(din), .addr(addr),
    .rd_act(rd_act), .rd_sel(rd_sel), .wr_commit(wr_commit),
    .cap_sel(cap_sel), .cap_din(cap_din), .cap_addr(cap_addr)
  );

  hbus_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .cap_sel(cap_sel),
    .cap_din(cap_din), .cap_addr(cap_addr), .busy(busy),
    .cal_start(cal_start), .cal_ovf(cal_ovf), .power_fail(power_fail),
    .ctrl(ctrl), .pf_flag(pf_flag), .cerr_flag(cerr_flag), .chan(chan),
    .start_req(start_req), .cal_req(cal_req)
  );

  hbus_rdmux #(.DW(DW), .RW(RW)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .rd_sel(rd_sel),
    .ctrl(ctrl), .pf_flag(pf_flag), .cerr_flag(cerr_flag), .busy(busy),
    .cal_active(cal_active), .result(result),
    .bus_oe(bus_oe), .bus_dout(bus_dout)
  );

  assign mode_latched = ctrl.mode;
  assign shc_mode     = ctrl.shc;
  assign pdown        = ctrl.pdown;

endmodule

// File: rtl/hbus_if_chk.sv
module hbus_if_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sfr,
  input logic          hbe,
  input logic          busy,
  input logic          power_fail,
  input logic          bus_oe,
  input logic [DW-1:0] bus_dout,
  input logic          start_req,
  input logic          cal_req,
  input logic          mode_latched,
  input logic          shc_mode,
  input logic          pdown
);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_dout == '0));

  p_hi_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !sfr && hbe) |-> (bus_dout[DW-1] == busy && bus_dout[6:4] == 3'b000));

  p_req_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_req, cal_req}));

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);

  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> !$past(busy));

  p_rsvd_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && sfr && !hbe) |-> (bus_dout == '0));

  p_pwr_fail_r12: assert property (@(posedge clk) disable iff (!rst_n)
    power_fail |=> (cal_req && !mode_latched && !shc_mode && !pdown));

endmodule

bind hbus_if hbus_if_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr(sfr), .hbe(hbe), .busy(busy),
  .power_fail(power_fail), .bus_oe(bus_oe), .bus_dout(bus_dout),
  .start_req(start_req), .cal_req(cal_req), .mode_latched(mode_latched),
  .shc_mode(shc_mode), .pdown(pdown)
);

// File: tb/hbus_if_test.sv
module hbus_if_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hbe = 1'b0, sfr = 1'b0;
  logic [7:0]  din = '0;
  logic [1:0]  addr = '0;
  logic        busy = 1'b0, cal_active = 1'b0, cal_start = 1'b0, cal_ovf = 1'b0;
  logic        power_fail = 1'b0;
  logic [11:0] result = '0;
  logic        bus_oe, start_req, cal_req, mode_latched, shc_mode, pdown;
  logic [7:0]  bus_dout;
  logic [1:0]  chan;

  int vectors = 0;
  int miscompares = 0;

  // bench model
  logic m_mode = 0, m_shc = 0, m_pd = 0, m_pf = 0, m_cerr = 0;
  logic [1:0]  m_chan = 0;
  logic [11:0] m_hold = 0;

  always #2 clk = ~clk;

  hbus_if uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .hbe(hbe), .sfr(sfr), .din(din), .addr(addr), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .busy(busy), .cal_active(cal_active),
    .cal_start(cal_start), .cal_ovf(cal_ovf), .power_fail(power_fail),
    .result(result), .start_req(start_req), .cal_req(cal_req), .chan(chan),
    .mode_latched(mode_latched), .shc_mode(shc_mode), .pdown(pdown)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic s, input logic h);
    logic [11:0] r;
    r = m_mode ? m_hold : result;
    case ({s, h})
      2'b00:   return r[7:0];
      2'b01:   return {busy, 3'b000, r[11:8]};
      2'b11:   return {busy, m_cerr, m_pf, 1'b0, m_pd, m_shc, cal_active, m_mode};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_state(input string req);
    chk({req, " mode"}, mode_latched, m_mode);
    chk({req, " shc"},  shc_mode, m_shc);
    chk({req, " pdown"}, pdown, m_pd);
    chk({req, " chan"}, chan, m_chan);
  endtask

  // Read: drive at negedge, check 1 ns later; optionally flip hbe mid-read
  task automatic do_read(input logic s, input logic h, input logic flip);
    @(negedge clk);
    sfr = s; hbe = h; cs_n = 0; rd_n = 0;
    #1;
    chk("R1 oe", bus_oe, 1'b1);
    chk((s && !h) ? "R11 rsvd read" : (s ? "R4 reg read" : (h ? "R3 high read" : "R2 low read")),
        bus_dout, exp_read(s, h));
    if (flip) begin
      hbe = ~h;
      #1;
      chk("R2 hbe follow", bus_dout, exp_read(s, ~h));
    end
    @(negedge clk);
    cs_n = 1; rd_n = 1;
    #1;
    chk("R1 idle oe", bus_oe, 1'b0);
    chk("R1 idle data", bus_dout, 8'h00);
  endtask

  task automatic do_write(input logic s, input logic h, input logic [7:0] d, input logic [1:0] a);
    logic exp_start, exp_cal;
    @(negedge clk);
    sfr = s; hbe = h; din = d; addr = a; cs_n = 0; wr_n = 0;
    @(negedge clk);
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    din = ~d; addr = ~a;
    exp_start = 0; exp_cal = 0;
    if (s && h) begin
      if (d[1]) exp_cal = 1; else exp_start = !busy;
      m_mode = d[0]; m_shc = d[2]; m_pd = d[3];
      if (!d[5]) m_pf = 0;
      m_chan = a;
    end else if (!s) begin
      exp_start = !busy && !m_shc;
      m_chan = a;
    end
    @(negedge clk);
    chk((s && !h) ? "R11 rsvd start" : (busy ? "R10 start" : (s ? "R6 start" : "R9 start")),
        start_req, exp_start);
    chk((s && !h) ? "R11 rsvd cal" : "R6 cal", cal_req, exp_cal);
    check_state((s && !h) ? "R11" : (s ? "R5" : "R8"));
    @(negedge clk);
    chk("R6 single pulse", {start_req, cal_req}, 2'b00);
  endtask

  task automatic set_busy(input logic v);
    @(negedge clk);
    if (busy && !v) m_hold = result;
    busy = v;
    @(negedge clk);
  endtask

  task automatic pulse_pf();
    @(negedge clk);
    power_fail = 1;
    @(negedge clk);
    power_fail = 0;
    m_pf = 1; m_mode = 0; m_shc = 0; m_pd = 0;
    chk("R12 cal_req", cal_req, 1'b1);
    check_state("R12");
  endtask

  task automatic pulse_cal(input logic ovf);
    @(negedge clk);
    if (ovf) cal_ovf = 1; else cal_start = 1;
    @(negedge clk);
    cal_ovf = 0; cal_start = 0;
    m_cerr = ovf;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check_state("R5 reset");
    chk("R6 reset req", {start_req, cal_req}, 2'b00);
    chk("R1 reset oe", bus_oe, 1'b0);

    // directed corners
    result = 12'hA5C;
    do_read(0, 0, 1);                  // R2 low byte and hbe follow
    do_read(0, 1, 1);                  // R3
    do_write(0, 0, 8'h00, 2'd3);       // R8 channel 3, R9 start
    do_write(0, 1, 8'h00, 2'd0);       // R8 channel 0
    do_write(1, 1, 8'h0D, 2'd2);       // R5 mode, pdown, shc
    do_read(1, 1, 0);                  // R4
    do_write(0, 0, 8'h00, 2'd1);       // R9 shc: no start
    do_write(1, 0, 8'hFF, 2'd3);       // R11 reserved write ignored
    do_read(1, 0, 0);                  // R11 reserved read
    do_write(1, 1, 8'h02, 2'd1);       // R6 calibration request
    pulse_pf();                        // R12
    do_read(1, 1, 0);
    do_write(1, 1, 8'h20, 2'd0);       // R7 D5 high keeps flag
    do_read(1, 1, 0);
    do_write(1, 1, 8'h00, 2'd0);       // R7 D5 low clears flag
    do_read(1, 1, 0);
    pulse_cal(1);                      // R13 set
    do_read(1, 1, 0);
    pulse_cal(0);                      // R13 clear
    do_read(1, 1, 0);
    set_busy(1);                       // R10 start blocked while busy
    do_write(0, 0, 8'h00, 2'd2);
    result = 12'h3C7;
    set_busy(0);                       // R14 capture at busy fall
    result = 12'hF18;
    do_write(1, 1, 8'h21, 2'd2);       // latched mode on
    do_read(0, 0, 0);                  // R14 held value
    do_read(0, 1, 0);
    do_write(1, 1, 8'h20, 2'd2);       // transparent
    do_read(0, 0, 0);                  // R14 live value

    // constrained random
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 7))
        0, 1: do_write(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       8'($urandom) & 8'hAF, 2'($urandom));
        2, 3: do_read(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)));
        4: set_busy(1'($urandom_range(0, 1)));
        5: begin @(negedge clk); result = 12'($urandom); cal_active = 1'($urandom); end
        6: pulse_cal(1'($urandom_range(0, 1)));
        default: if ($urandom_range(0, 3) == 0) pulse_pf();
      endcase
    end
    finish_run();
  end

endmodule